// File: doc/BRIEF.md
# Two-Street Signal Controller with Parade Hold

This block drives the signal lights at a crossing of two streets, A and B. Each street has one presence sensor, which is high while vehicles wait, and one three-colour light. One clock tick stands for one fixed interval of about five seconds. Real-time timers, pedestrian inputs and lamp drivers sit outside the block.

The block is built from two small Moore machines that work together. The phase machine steps the lights through four phases: A green, A yellow, B green and B yellow. It stays in A green while street A is occupied, and it stays in B green while street B is occupied. The mode machine holds a parade flag, which one input sets and another clears. While the flag is up, the phase machine keeps its normal sequence until street B turns green. It then holds that phase, whatever the B sensor shows, until the flag is cleared.

Top module: `tlc_factored_top`

## Requirements
- R1: A synchronous reset, sampled on a rising edge, puts the lights in phase A-green and clears the parade flag. After that edge, light_a reads green and light_b reads red, whatever the other inputs are.
- R2: In A-green, the phase holds while sense_a is 1. It moves to A-yellow on the next edge when sense_a is 0.
- R3: A-yellow always moves to B-green on the next edge, regardless of any input.
- R4: In B-green with the parade flag clear, the phase holds while sense_b is 1. It moves to B-yellow on the next edge when sense_b is 0.
- R5: B-yellow always moves to A-green on the next edge, regardless of any input.
- R6: The light codes are green = 2'b00, yellow = 2'b01 and red = 2'b10. The code 2'b11 never appears on light_a or light_b. The phases show these lights on (light_a, light_b):
  - A-green: (green, red)
  - A-yellow: (yellow, red)
  - B-green: (red, green)
  - B-yellow: (red, yellow)
- R7: When parade_on is 1 and parade_off is 0 at an edge, parade_mode reads 1 after that edge. When parade_off is 1 and parade_on is 0 at an edge, parade_mode reads 0 after that edge. Otherwise parade_mode keeps its value when neither input is asserted.
- R8: When parade_on and parade_off are both 1 at an edge, parade_mode keeps its value.
- R9: While parade_mode is 1, the B-green phase is held at every edge, whatever sense_b is.
- R10: The parade flag does not change how the A-green, A-yellow and B-yellow phases behave. The sequence keeps running until it reaches B-green.
- R11: At least one of the two lights is red in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each rising edge is one tick |
| rst | input | 1 | Synchronous reset, active high |
| sense_a | input | 1 | Vehicle present on street A |
| sense_b | input | 1 | Vehicle present on street B |
| parade_on | input | 1 | Request to enter parade mode |
| parade_off | input | 1 | Request to leave parade mode |
| light_a | output | 2 | Light code for street A |
| light_b | output | 2 | Light code for street B |
| parade_mode | output | 1 | Parade flag from the mode machine |

## Verification
Both outputs are decoded from state alone, so a wrong phase shows up on the light pins in the same cycle the state goes wrong. A phase that is skipped or repeated appears as a colour pair that does not belong to the expected phase. A wrong parade flag shows up on parade_mode at once. It appears on the lights only later, when B-green is either left or held when it should not be, which can be several ticks after the bad mode edge. The reference model is compared on every cycle, with random sensor and mode traffic mixed in, so that gap is covered.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    localparam int LIGHT_W = 2;
    localparam int PHASE_W = 2;

    typedef enum logic [LIGHT_W-1:0] {
        LT_GREEN  = 2'b00,
        LT_YELLOW = 2'b01,
        LT_RED    = 2'b10
    } light_e;

    // Phase code bits feed the next-state equations directly.
    typedef enum logic [PHASE_W-1:0] {
        PH_A_GO   = 2'b00,
        PH_A_WARN = 2'b01,
        PH_B_GO   = 2'b10,
        PH_B_WARN = 2'b11
    } phase_e;

    typedef struct packed {
        logic parade;
    } mode_regs_t;

    typedef struct packed {
        phase_e phase;
    } phase_regs_t;

endpackage

// File: rtl/tlc_mode_fsm.sv
module tlc_mode_fsm
    import tlc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic parade_o
);

    mode_regs_t mode_d;
    mode_regs_t mode_q;

    always_comb begin
        mode_d = mode_q;
        // Simultaneous set and clear leave the mode unchanged.
        if (set_i && !clr_i) begin
            mode_d.parade = 1'b1;
        end else if (clr_i && !set_i) begin
            mode_d.parade = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q.parade <= 1'b0;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign parade_o = mode_q.parade;

endmodule

// File: rtl/tlc_phase_fsm.sv
module tlc_phase_fsm
    import tlc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sense_a,
    input  logic   sense_b,
    input  logic   park,
    output phase_e phase_o
);

    phase_regs_t ph_d;
    phase_regs_t ph_q;
    logic [PHASE_W-1:0] cur_bits;
    logic [PHASE_W-1:0] nxt_bits;

    assign cur_bits = ph_q.phase;

    always_comb begin
        // Bit 1 flips on every odd phase; bit 0 is set when leaving a green.
        // Parking suppresses the exit from B-green.
        nxt_bits[1] = cur_bits[1] ^ cur_bits[0];
        nxt_bits[0] = (~cur_bits[1] & ~cur_bits[0] & ~sense_a)
                    | ( cur_bits[1] & ~cur_bits[0] & ~sense_b & ~park);
        ph_d.phase  = phase_e'(nxt_bits);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q.phase <= PH_A_GO;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign phase_o = ph_q.phase;

endmodule

// File: rtl/tlc_light_dec.sv
module tlc_light_dec
    import tlc_pkg::*;
(
    input  phase_e             phase_i,
    output logic [LIGHT_W-1:0] light_a_o,
    output logic [LIGHT_W-1:0] light_b_o
);

    logic s1;
    logic s0;

    assign s1 = phase_i[1];
    assign s0 = phase_i[0];

    always_comb begin
        light_a_o[1] = s1;
        light_a_o[0] = ~s1 & s0;
        light_b_o[1] = ~s1;
        light_b_o[0] = s1 & s0;
    end

endmodule

// File: rtl/tlc_factored_top.sv
module tlc_factored_top
    import tlc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sense_a,
    input  logic       sense_b,
    input  logic       parade_on,
    input  logic       parade_off,
    output logic [1:0] light_a,
    output logic [1:0] light_b,
    output logic       parade_mode
);

    logic   parade_flag;
    phase_e phase;

    tlc_mode_fsm u_mode (
        .clk      (clk),
        .rst      (rst),
        .set_i    (parade_on),
        .clr_i    (parade_off),
        .parade_o (parade_flag)
    );

    tlc_phase_fsm u_phase (
        .clk     (clk),
        .rst     (rst),
        .sense_a (sense_a),
        .sense_b (sense_b),
        .park    (parade_flag),
        .phase_o (phase)
    );

    tlc_light_dec u_dec (
        .phase_i   (phase),
        .light_a_o (light_a),
        .light_b_o (light_b)
    );

    assign parade_mode = parade_flag;

endmodule

// File: rtl/tlc_factored_checker.sv
module tlc_factored_checker (
    input logic       clk,
    input logic       rst,
    input logic       sense_a,
    input logic       sense_b,
    input logic       parade_on,
    input logic       parade_off,
    input logic [1:0] light_a,
    input logic [1:0] light_b,
    input logic       parade_mode
);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (light_a == 2'b00 && light_b == 2'b10 && !parade_mode));

    p_hold_a_green_r2: assert property (@(posedge clk) disable iff (rst)
        (light_a == 2'b00 && sense_a) |=> light_a == 2'b00);

    p_leave_a_green_r2: assert property (@(posedge clk) disable iff (rst)
        (light_a == 2'b00 && !sense_a) |=> light_a == 2'b01);

    p_a_yellow_to_b_green_r3: assert property (@(posedge clk) disable iff (rst)
        (light_a == 2'b01) |=> light_b == 2'b00);

    p_leave_b_green_r4: assert property (@(posedge clk) disable iff (rst)
        (light_b == 2'b00 && !sense_b && !parade_mode) |=> light_b == 2'b01);

    p_b_yellow_to_a_green_r5: assert property (@(posedge clk) disable iff (rst)
        (light_b == 2'b01) |=> light_a == 2'b00);

    p_no_code_11_r6: assert property (@(posedge clk) disable iff (rst)
        light_a != 2'b11 && light_b != 2'b11);

    p_mode_set_r7: assert property (@(posedge clk) disable iff (rst)
        (parade_on && !parade_off) |=> parade_mode);

    p_mode_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (parade_off && !parade_on) |=> !parade_mode);

    p_mode_both_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (parade_on && parade_off) |=> $stable(parade_mode));

    p_parade_park_r9: assert property (@(posedge clk) disable iff (rst)
        (parade_mode && light_b == 2'b00) |=> light_b == 2'b00);

    p_one_red_r11: assert property (@(posedge clk) disable iff (rst)
        light_a == 2'b10 || light_b == 2'b10);

endmodule

bind tlc_factored_top tlc_factored_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .sense_a     (sense_a),
    .sense_b     (sense_b),
    .parade_on   (parade_on),
    .parade_off  (parade_off),
    .light_a     (light_a),
    .light_b     (light_b),
    .parade_mode (parade_mode)
);

// File: tb/sim_tlc_factored_top.sv
module sim_tlc_factored_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sense_a = 1'b0;
    logic       sense_b = 1'b0;
    logic       parade_on = 1'b0;
    logic       parade_off = 1'b0;
    logic [1:0] light_a;
    logic [1:0] light_b;
    logic       parade_mode;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;

    // Reference model: phase 0 = A green, 1 = A yellow, 2 = B green, 3 = B yellow
    int m_phase = 0;
    bit m_mode = 1'b0;

    tlc_factored_top u0 (
        .clk         (clk),
        .rst         (rst),
        .sense_a     (sense_a),
        .sense_b     (sense_b),
        .parade_on   (parade_on),
        .parade_off  (parade_off),
        .light_a     (light_a),
        .light_b     (light_b),
        .parade_mode (parade_mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        int nxt;
        if (rst) begin
            m_phase = 0;
            m_mode  = 1'b0;
        end else begin
            case (m_phase)
                0:       nxt = sense_a ? 0 : 1;
                1:       nxt = 2;
                2:       nxt = (m_mode || sense_b) ? 2 : 3;
                default: nxt = 0;
            endcase
            if (parade_on && !parade_off)      m_mode = 1'b1;
            else if (parade_off && !parade_on) m_mode = 1'b0;
            m_phase = nxt;
        end
    end

    function automatic logic [1:0] exp_a(int ph);
        case (ph)
            0:       return 2'b00;
            1:       return 2'b01;
            default: return 2'b10;
        endcase
    endfunction

    function automatic logic [1:0] exp_b(int ph);
        case (ph)
            2:       return 2'b00;
            3:       return 2'b01;
            default: return 2'b10;
        endcase
    endfunction

    task automatic check(input string tag);
        n_checks++;
        if (light_a !== exp_a(m_phase) || light_b !== exp_b(m_phase)
            || parade_mode !== m_mode) begin
            n_fails++;
            $display("FAIL %s: a=%b b=%b m=%b expected a=%b b=%b m=%b", tag,
                     light_a, light_b, parade_mode,
                     exp_a(m_phase), exp_b(m_phase), m_mode);
        end
        n_checks++;
        if (light_a == 2'b11 || light_b == 2'b11) begin
            n_fails++;
            $display("FAIL R6: a=%b b=%b expected no code 11", light_a, light_b);
        end
        n_checks++;
        if (light_a != 2'b10 && light_b != 2'b10) begin
            n_fails++;
            $display("FAIL R11: a=%b b=%b expected one red", light_a, light_b);
        end
    endtask

    // Drive inputs after a falling edge, cross one rising edge, check at the next falling edge.
    task automatic cyc(input bit ta, input bit tb, input bit p, input bit r, input string tag);
        sense_a = ta; sense_b = tb; parade_on = p; parade_off = r;
        @(negedge clk);
        check(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] lfsr;
        lfsr = 8'hA5;
        @(negedge clk);
        @(negedge clk);
        check("R1 reset");
        rst = 1'b0;
        // R2: hold in A green while occupied, then advance
        cyc(1, 0, 0, 0, "R2 hold");
        cyc(1, 1, 0, 0, "R2 hold");
        cyc(0, 1, 0, 0, "R2 advance");
        // R3: A yellow advances whatever the inputs
        cyc(1, 0, 0, 0, "R3");
        // R4: B green holds while occupied, then advances
        cyc(1, 1, 0, 0, "R4 hold");
        cyc(0, 1, 0, 0, "R4 hold");
        cyc(1, 0, 0, 0, "R4 advance");
        // R5: B yellow returns to A green whatever the inputs
        cyc(0, 1, 0, 0, "R5");
        // R7: set parade; R10: normal sequence continues until B green
        cyc(1, 0, 1, 0, "R7 set");
        cyc(1, 0, 0, 0, "R10 hold A");
        cyc(0, 0, 0, 0, "R10 advance A");
        cyc(0, 0, 0, 0, "R10 to B green");
        // R9: parked in B green with street B empty
        cyc(0, 0, 0, 0, "R9 park");
        cyc(1, 0, 0, 0, "R9 park");
        cyc(0, 0, 0, 0, "R9 park");
        // R8: both requests keep parade on
        cyc(0, 0, 1, 1, "R8 hold on");
        cyc(0, 0, 0, 0, "R9 still parked");
        // R7: clear parade, then B green is released
        cyc(0, 1, 0, 1, "R7 clear");
        cyc(0, 0, 0, 0, "R4 release");
        cyc(0, 0, 1, 1, "R8 hold off");
        cyc(0, 0, 0, 0, "R5 after parade");
        // R1: reset in the middle of parade with inputs active
        cyc(0, 0, 1, 0, "R7 set again");
        cyc(0, 0, 0, 0, "R10 run");
        rst = 1'b1;
        cyc(0, 0, 1, 0, "R1 mid-run reset");
        rst = 1'b0;
        // R11 and R6: random traffic with mode requests
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            cyc(lfsr[0], lfsr[1], lfsr[2] & lfsr[5], lfsr[3] & lfsr[6], "R11 random");
        end
        finish_run();
    end

endmodule